// File: doc/BRIEF.md
# Multi-mode trace capture buffer

This block stores trace words in an on-chip memory and gives them back in one of three ways, chosen at run time. In circular capture mode the memory is a ring that keeps the newest trace. When the ring is full, each new word replaces the oldest one. Capture can stop on its own a programmed number of words after a trigger pulse. The captured window is then read out, oldest word first, through a data register. In hardware FIFO mode the block sits between a trace source and a downstream sink. It absorbs bursts, and it holds the source off when it has no room, so no word is lost. In software-read mode the words collect in the same FIFO, and each read of the data register removes one of them.

The block has a small register port. Through it, software sets the mode, the capture enable, the trigger-stop enable and the post-trigger count. Software also reads the status flags, the fill level, both pointers and the trace data. Read data is registered and appears on `reg_rdata` one cycle after the read strobe.

Top module: `trace_capture_buf`

## Requirements
- R1: In circular mode (CTRL[2:1]=0), while capture runs, `in_ready` stays high even when the memory is full. Each word accepted while full replaces the oldest stored word. The level stays at DEPTH, and the wrapped flag (STATUS bit 4) is set.
- R2: In circular mode `out_valid` is never high. A read of DATA (address 6) while capture is still running returns all ones and leaves the level unchanged. Once capture has ended (enable cleared or stopped), successive DATA reads return the stored words oldest first.
- R3: With trigger stop enabled (CTRL bit 3) in circular mode, a high `trig_in` in a cycle while capture runs sets the triggered flag (STATUS bit 3). Exactly POST (address 1) further words are then accepted. After that, `in_ready` drops and the stopped flag (STATUS bit 2) is set.
- R4: In hardware FIFO mode (CTRL[2:1]=1), `in_ready` is low whenever the memory holds DEPTH words. Every accepted word appears on `out_data` exactly once, in arrival order.
- R5: In hardware FIFO mode, `out_valid` is high whenever at least one word is stored, and a word leaves on a cycle with `out_valid` and `out_ready` both high.
- R6: In software-read mode (CTRL[2:1]=2), `out_valid` stays low. Each DATA read removes one word, and that word appears on `reg_rdata` in the following cycle.
- R7: A DATA read while the memory is empty returns 32'hFFFFFFFF and leaves the read pointer (address 4) unchanged.
- R8: A write to CTRL (address 0) changes the mode field only if capture was disabled (CTRL bit 0 clear) before that write.
- R9: A CTRL write that sets bit 0 while capture is disabled clears both pointers, the level, the wrapped, triggered and stopped flags.
- R10: STATUS (address 2) reports full in bit 0 and empty in bit 1. LEVEL (address 3) reports the number of stored words, RDPTR (address 4) the read pointer and WRPTR (address 5) the write pointer.
- R11: After reset, capture is disabled in circular mode (CTRL reads 0), STATUS reads 2 (empty), and both `in_ready` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Trace word offered on the input |
| in_data | input | DW | Trace word |
| in_ready | output | 1 | Block accepts the offered word this cycle |
| trig_in | input | 1 | Trigger pulse |
| out_valid | output | 1 | Stored word offered downstream (hardware FIFO mode) |
| out_data | output | DW | Oldest stored word |
| out_ready | input | 1 | Sink takes the offered word |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after the read strobe |

## Verification
The assertions take for granted that the register port never carries a read and a write in the same cycle. They also assume that `reg_addr` is stable and meaningful whenever a strobe is high, and that the downstream sink only samples `out_data` while `out_valid` is high. The bench issues one register access per task, with an idle cycle between accesses. It changes stream inputs only at the falling edge, and it starts the flow-controlled transfer only after the mode has been fixed with capture disabled.

// File: rtl/trace_buf_pkg.sv
package trace_buf_pkg;

    typedef enum logic [1:0] {
        MODE_CIRC   = 2'd0,
        MODE_HWFIFO = 2'd1,
        MODE_SWFIFO = 2'd2,
        MODE_RSVD   = 2'd3
    } cap_mode_e;

    localparam int RW = 32;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_POST  = 3'd1;
    localparam logic [2:0] RA_STAT  = 3'd2;
    localparam logic [2:0] RA_LEVEL = 3'd3;
    localparam logic [2:0] RA_RDPTR = 3'd4;
    localparam logic [2:0] RA_WRPTR = 3'd5;
    localparam logic [2:0] RA_DATA  = 3'd6;

    localparam int CB_EN   = 0;
    localparam int CB_MODE = 1;
    localparam int CB_TRIG = 3;

endpackage

// File: rtl/trace_buf_mem.sv
module trace_buf_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/trace_buf_trig.sv
module trace_buf_trig #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          arm,
    input  logic          trig_in,
    input  logic          accept,
    input  logic [CW-1:0] post_cnt,
    output logic          triggered,
    output logic          stopped
);

    typedef struct packed {
        logic          triggered;
        logic          stopped;
        logic [CW-1:0] remain;
    } trig_st_t;

    trig_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (arm && !st_q.triggered && trig_in) begin
            st_d.triggered = 1'b1;
            st_d.remain    = post_cnt;
            if (post_cnt == '0) begin
                st_d.stopped = 1'b1;
            end
        end else if (st_q.triggered && !st_q.stopped && accept) begin
            st_d.remain = st_q.remain - 1'b1;
            if (st_q.remain == CW'(1)) begin
                st_d.stopped = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign triggered = st_q.triggered;
    assign stopped   = st_q.stopped;

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
    import trace_buf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 256,
    parameter int CW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          trig_in,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready,
    input  logic          reg_wr_en,
    input  logic          reg_rd_en,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] wr_ptr;
        logic [LW-1:0] level;
        logic          wrapped;
        logic          enable;
        cap_mode_e     mode;
        logic          trig_en;
        logic [CW-1:0] post;
        logic [RW-1:0] rdata;
    } buf_st_t;

    buf_st_t st_d, st_q;

    logic          full, empty, capturing, is_circ, is_hw, is_sw;
    logic          push, overwrite, pop_out, pop_reg, pop;
    logic          ctrl_wr, start, rd_allowed;
    logic          triggered, stopped;
    logic [DW-1:0] mem_rd;

    // Signals exposed to the bound checker
    logic [1:0]    mode_w;
    logic          enable_w;
    logic [LW-1:0] level_w;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (st_q.level == LW'(DEPTH));
    assign empty     = (st_q.level == '0);
    assign capturing = st_q.enable && !stopped;
    assign is_circ   = (st_q.mode == MODE_CIRC);
    assign is_hw     = (st_q.mode == MODE_HWFIFO);
    assign is_sw     = !is_circ && !is_hw;

    assign in_ready  = capturing && (is_circ || !full);
    assign push      = in_valid && in_ready;
    assign overwrite = push && full;
    assign out_valid = is_hw && !empty;
    assign out_data  = mem_rd;
    assign pop_out   = out_valid && out_ready;

    assign rd_allowed = is_sw || (is_circ && !capturing);
    assign pop_reg    = reg_rd_en && (reg_addr == RA_DATA) && rd_allowed && !empty;
    assign pop        = pop_out || pop_reg;

    assign ctrl_wr = reg_wr_en && (reg_addr == RA_CTRL);
    assign start   = ctrl_wr && reg_wdata[CB_EN] && !st_q.enable;

    trace_buf_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .wr_en   (push),
        .wr_addr (st_q.wr_ptr),
        .wr_data (in_data),
        .rd_addr (st_q.rd_ptr),
        .rd_data (mem_rd)
    );

    trace_buf_trig #(.CW(CW)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .arm       (capturing && is_circ && st_q.trig_en),
        .trig_in   (trig_in),
        .accept    (push),
        .post_cnt  (st_q.post),
        .triggered (triggered),
        .stopped   (stopped)
    );

    always_comb begin
        st_d = st_q;

        // Pointer engine
        if (push) begin
            st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        end
        if (pop || overwrite) begin
            st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        end
        unique case ({push && !overwrite, pop})
            2'b10:   st_d.level = st_q.level + 1'b1;
            2'b01:   st_d.level = st_q.level - 1'b1;
            default: st_d.level = st_q.level;
        endcase
        if (overwrite) begin
            st_d.wrapped = 1'b1;
        end

        // Register writes
        if (ctrl_wr) begin
            st_d.enable  = reg_wdata[CB_EN];
            st_d.trig_en = reg_wdata[CB_TRIG];
            if (!st_q.enable) begin
                st_d.mode = cap_mode_e'(reg_wdata[CB_MODE +: 2]);
            end
        end
        if (reg_wr_en && (reg_addr == RA_POST)) begin
            st_d.post = reg_wdata[CW-1:0];
        end
        if (start) begin
            st_d.rd_ptr  = '0;
            st_d.wr_ptr  = '0;
            st_d.level   = '0;
            st_d.wrapped = 1'b0;
        end

        // Register reads
        if (reg_rd_en) begin
            unique case (reg_addr)
                RA_CTRL:  st_d.rdata = RW'({st_q.trig_en, st_q.mode, st_q.enable});
                RA_POST:  st_d.rdata = RW'(st_q.post);
                RA_STAT:  st_d.rdata = RW'({st_q.wrapped, triggered, stopped, empty, full});
                RA_LEVEL: st_d.rdata = RW'(st_q.level);
                RA_RDPTR: st_d.rdata = RW'(st_q.rd_ptr);
                RA_WRPTR: st_d.rdata = RW'(st_q.wr_ptr);
                RA_DATA:  st_d.rdata = pop_reg ? RW'(mem_rd) : '1;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign mode_w    = st_q.mode;
    assign enable_w  = st_q.enable;
    assign level_w   = st_q.level;

endmodule

// File: rtl/trace_capture_buf_chk.sv
module trace_capture_buf_chk #(
    parameter int DEPTH = 256,
    parameter int LW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          enable,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          stopped,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          reg_wr_en,
    input logic          reg_rd_en,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_rdata
);

    assert_overwrite_keeps_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && full && in_valid && in_ready) |=> full);

    assert_no_stream_circ_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> !out_valid);

    assert_stop_closes_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !in_ready);

    assert_full_blocks_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && full) |-> !in_ready);

    assert_valid_when_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && !empty) |-> out_valid);

    assert_no_stream_swread_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1]) |-> !out_valid);

    assert_empty_read_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == 3'd6 && empty) |=> (reg_rdata == 32'hFFFF_FFFF));

    assert_mode_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && reg_wr_en && reg_addr == 3'd0) |=> $stable(mode));

    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

endmodule

bind trace_capture_buf trace_capture_buf_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_w),
    .enable    (enable_w),
    .level     (level_w),
    .full      (full),
    .empty     (empty),
    .stopped   (stopped),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/trace_capture_buf_tb.sv
`timescale 1ns/1ps
module trace_capture_buf_tb;

    localparam int DW    = 32;
    localparam int DEPTH = 16;
    localparam int CW    = 16;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          trig_in = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ready = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic          reg_rd_en = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    trace_capture_buf #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .trig_in(trig_in),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push(input logic [DW-1:0] d, input logic trig, output logic acc);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; trig_in = trig;
        #1 acc = in_ready;
        @(negedge clk);
        in_valid = 1'b0; trig_in = 1'b0;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        chk("R11 in_ready after reset", 32'(in_ready), 0);
        chk("R11 out_valid after reset", 32'(out_valid), 0);
        reg_read(3'd0, v); chk("R11 CTRL after reset", v, 0);
        reg_read(3'd2, v); chk("R11 STATUS after reset", v, 32'h2);
    endtask

    task automatic test_circular();
        logic [31:0] v;
        logic acc;
        reg_write(3'd0, 32'h1);
        for (int i = 0; i < DEPTH + 5; i++) begin
            push(32'h100 + 32'(i), 1'b0, acc);
            chk("R1 accept while wrapping", 32'(acc), 1);
        end
        reg_read(3'd2, v); chk("R1 status full+wrapped", v, 32'h11);
        reg_read(3'd3, v); chk("R1 level saturates", v, DEPTH);
        chk("R2 no stream in circular", 32'(out_valid), 0);
        reg_read(3'd6, v); chk("R2 read during capture", v, ONES);
        reg_read(3'd3, v); chk("R2 level kept during capture read", v, DEPTH);
        reg_write(3'd0, 32'h0);
        for (int i = 0; i < DEPTH; i++) begin
            reg_read(3'd6, v);
            chk("R2 oldest-first readout", v, 32'h105 + 32'(i));
        end
        reg_read(3'd2, v); chk("R10 status empty+wrapped", v, 32'h12);
        reg_read(3'd4, v); chk("R10 read pointer", v, 5);
        reg_read(3'd5, v); chk("R10 write pointer", v, 5);
        reg_read(3'd6, v); chk("R7 empty read value", v, ONES);
        reg_read(3'd4, v); chk("R7 read pointer unmoved", v, 5);
    endtask

    task automatic test_trigger();
        logic [31:0] v;
        logic acc;
        reg_write(3'd1, 32'd3);
        reg_write(3'd0, 32'h9);
        reg_read(3'd4, v); chk("R9 read pointer cleared", v, 0);
        reg_read(3'd5, v); chk("R9 write pointer cleared", v, 0);
        reg_read(3'd2, v); chk("R9 flags cleared", v, 32'h2);
        for (int i = 0; i < 9; i++) begin
            push(32'h200 + 32'(i), (i == 4), acc);
            chk("R3 post-trigger acceptance", 32'(acc), (i < 8) ? 1 : 0);
        end
        chk("R3 input closed after stop", 32'(in_ready), 0);
        reg_read(3'd2, v); chk("R3 stopped+triggered", v, 32'hC);
        reg_read(3'd3, v); chk("R3 words captured", v, 8);
        for (int i = 0; i < 8; i++) begin
            reg_read(3'd6, v);
            chk("R3 window readout", v, 32'h200 + 32'(i));
        end
    endtask

    task automatic test_hwfifo();
        logic [31:0] v;
        logic acc;
        int tx, rx, cyc;
        logic got;
        reg_write(3'd0, 32'h0);
        reg_write(3'd0, 32'h2);
        reg_write(3'd0, 32'h3);
        for (int i = 0; i < DEPTH + 3; i++) begin
            push(32'h300 + 32'(i), 1'b0, acc);
            chk("R4 backpressure when full", 32'(acc), (i < DEPTH) ? 1 : 0);
        end
        chk("R5 out_valid with data", 32'(out_valid), 1);
        reg_read(3'd3, v); chk("R4 level at full", v, DEPTH);
        reg_write(3'd0, 32'h5);
        reg_read(3'd0, v); chk("R8 mode locked while enabled", v, 32'h3);
        tx = DEPTH; rx = 0; cyc = 0;
        @(negedge clk);
        while (rx < DEPTH + 24 && cyc < 2000) begin
            in_valid  = (tx < DEPTH + 24);
            in_data   = 32'h300 + 32'(tx);
            out_ready = (cyc % 3) != 2;
            #1;
            acc = in_valid && in_ready;
            got = out_valid && out_ready;
            if (got) chk("R4 lossless in-order output", out_data, 32'h300 + 32'(rx));
            if (acc) tx++;
            if (got) rx++;
            cyc++;
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b0;
        chk("R4 all words delivered", rx, DEPTH + 24);
        #1 chk("R5 out_valid low when empty", 32'(out_valid), 0);
    endtask

    task automatic test_swfifo();
        logic [31:0] v;
        logic acc;
        reg_write(3'd0, 32'h2);
        reg_write(3'd0, 32'h4);
        reg_write(3'd0, 32'h5);
        reg_read(3'd2, v); chk("R9 empty after enable", v, 32'h2);
        reg_read(3'd3, v); chk("R9 level cleared", v, 0);
        for (int i = 0; i < 3; i++) begin
            push(32'h400 + 32'(i), 1'b0, acc);
            chk("R6 accept in sw mode", 32'(acc), 1);
        end
        chk("R6 no stream in sw mode", 32'(out_valid), 0);
        reg_read(3'd3, v); chk("R10 level", v, 3);
        reg_read(3'd5, v); chk("R10 write pointer", v, 3);
        for (int i = 0; i < 3; i++) begin
            reg_read(3'd6, v);
            chk("R6 register pop", v, 32'h400 + 32'(i));
        end
        reg_read(3'd6, v); chk("R7 empty read value", v, ONES);
        reg_read(3'd4, v); chk("R7 pointer unmoved", v, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_circular();
        test_trigger();
        test_hwfifo();
        test_swfifo();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule